// File: doc/BRIEF.md
# Serial-Fed Pulse-Density Audio Output

This block turns a stream of 8-bit mono audio bytes from a UART receiver into a one-bit pulse-density signal for an audio pin. The receiver presents each byte together with a strobe that lasts one clock. The block captures the byte on that cycle and keeps it in a holding register.

Each byte arrives in offset binary. The block turns it into a signed sample and attenuates it with a 3-bit volume setting. A first-order error-feedback accumulator then converts the attenuated level into a stream of pulses whose density follows the level. The output bit passes through a flip-flop before it reaches the pin.

The modulator only takes a new level at the boundary of a fixed hold period. That period is 2^(MSBL+1) clocks, where MSBL is the index of the accumulator's top bit. A separate output goes high on every strobe and stays high for a long, parameterised stretch, so that receive activity can be seen on an indicator.

Top module: `audio_pdm_dac`

## Requirements
- R1: The holding register loads `rx_byte` only on a clock edge where `rx_valid` is 1. Changes on `rx_byte` at any other time have no effect on the pulse stream.
- R2: A byte is read as offset binary. 0x00 is the most negative level (-128), 0x80 is zero and 0xFF is +127. The signed value is the byte with only bit 7 inverted.
- R3: The signed sample is shifted right arithmetically by (7 - `volume`) bits, with the sign kept. Volume 7 gives full scale and volume 0 gives a shift of 7.
- R4: The modulator takes a new level only at the end of a hold period of 2^(SAMPLE_W+1) = 512 clocks, counted from reset release. It keeps that level for the whole next period, so a byte captured in the middle of a period has no effect until the next period starts.
- R5: The modulator level u is the scaled signed sample with bit 7 inverted (an unsigned value, 0..255). For the level used in period m, the pin is 1 in exactly 2*u of the 512 cycles in the window that starts two clocks after period m begins, because the accumulator adds one clock and the output flip-flop adds one more.
- R6: If `rx_valid` pulses more than once within one hold period, the last byte captured before the boundary is the one that is used.
- R7: Reset is synchronous and active high. It loads the holding register with signed zero and clears the accumulator and `audio_out`, so the first period after reset has a pulse density of exactly 50 percent (256 ones).
- R8: `rx_active` is 1 from the edge that captures a strobe through 2^ACT_LOG2 cycles in total, and 0 after that. A new strobe restarts the stretch. It is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe marking a received byte |
| rx_byte | input | 8 | Received audio byte, offset binary |
| volume | input | 3 | Attenuation setting, 7 = full scale |
| audio_out | output | 1 | Registered pulse-density audio bit |
| rx_active | output | 1 | Stretched receive activity indicator |

## Verification
The assertions assume that `rx_valid` is a clean one-cycle strobe and that `volume` holds steady across each hold-period boundary, because the scaler samples it combinationally at that edge. The stimulus changes `volume` only in the cycle that carries a strobe, well inside a period. Every strobe is placed at a fixed offset within its period, so each boundary sees a settled byte and a settled volume. One deliberate late strobe, placed a few clocks before a boundary, checks that the new level waits for that boundary.

// File: rtl/pdm_dac_pkg.sv
package pdm_dac_pkg;
    localparam int SAMPLE_W = 8;
    localparam int VOL_W    = 3;
    localparam logic [VOL_W-1:0] VOL_MAX = '1;

    typedef logic signed [SAMPLE_W-1:0] pcm_t;
    typedef logic        [SAMPLE_W-1:0] code_t;
    typedef logic        [VOL_W-1:0]    vol_t;

    typedef struct packed {
        logic [SAMPLE_W:0] acc;
        code_t             level;
    } mod_state_t;

    typedef enum logic {ACT_IDLE = 1'b0, ACT_LIT = 1'b1} act_state_t;

    function automatic pcm_t offset_to_pcm(code_t c);
        return pcm_t'({~c[SAMPLE_W-1], c[SAMPLE_W-2:0]});
    endfunction

    function automatic code_t pcm_to_offset(pcm_t s);
        return {~s[SAMPLE_W-1], s[SAMPLE_W-2:0]};
    endfunction

    function automatic pcm_t scale_pcm(pcm_t s, vol_t v);
        vol_t sh;
        sh = VOL_MAX - v;
        return s >>> sh;
    endfunction
endpackage

// File: rtl/sample_capture.sv
module sample_capture
    import pdm_dac_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  strobe,
    input  code_t byte_in,
    output pcm_t  sample_q
);
    always_ff @(posedge clk) begin
        if (rst)
            sample_q <= '0;
        else if (strobe)
            sample_q <= offset_to_pcm(byte_in);
    end

    // R1: without a strobe the held sample does not move
    a_r1_hold_without_strobe: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> $stable(sample_q));
    // R7: reset leaves signed zero in the holding register
    a_r7_reset_midscale: assert property (@(posedge clk)
        rst |=> (sample_q == '0));
endmodule

// File: rtl/vol_scaler.sv
module vol_scaler
    import pdm_dac_pkg::*;
(
    input  pcm_t  sample,
    input  vol_t  vol,
    output code_t level
);
    pcm_t scaled;
    always_comb begin
        scaled = scale_pcm(sample, vol);
        level  = pcm_to_offset(scaled);
    end
endmodule

// File: rtl/pdm_modulator.sv
module pdm_modulator
    import pdm_dac_pkg::*;
#(
    parameter int HOLD_LOG2 = SAMPLE_W + 1
) (
    input  logic  clk,
    input  logic  rst,
    input  code_t level_in,
    output logic  pin
);
    localparam code_t MID = code_t'(1) << (SAMPLE_W - 1);

    logic [HOLD_LOG2-1:0] hold_cnt;
    mod_state_t           st;
    logic                 boundary;
    logic [SAMPLE_W:0]    acc_next;

    always_comb begin
        boundary = &hold_cnt;
        acc_next = {1'b0, st.acc[SAMPLE_W-1:0]} + {1'b0, st.level};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_cnt <= '0;
            st.acc   <= '0;
            st.level <= MID;
            pin      <= 1'b0;
        end else begin
            hold_cnt <= hold_cnt + 1'b1;
            st.acc   <= acc_next;
            if (boundary)
                st.level <= level_in;
            pin <= st.acc[SAMPLE_W];
        end
    end

    // R4: the modulator level only moves at a hold-period boundary
    a_r4_level_held: assert property (@(posedge clk) disable iff (rst)
        !boundary |=> $stable(st.level));
    // R5: a level of zero never produces a carry on the next edge
    a_r5_zero_no_carry: assert property (@(posedge clk) disable iff (rst)
        (st.level == '0 && !st.acc[SAMPLE_W]) |=> !st.acc[SAMPLE_W]);
endmodule

// File: rtl/activity_stretch.sv
module activity_stretch
    import pdm_dac_pkg::*;
#(
    parameter int LEN_LOG2 = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic trigger,
    output logic active
);
    act_state_t          state;
    logic [LEN_LOG2-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ACT_IDLE;
            cnt   <= '0;
        end else if (trigger) begin
            state <= ACT_LIT;
            cnt   <= '0;
        end else if (state == ACT_LIT) begin
            cnt <= cnt + 1'b1;
            if (&cnt)
                state <= ACT_IDLE;
        end
    end

    assign active = (state == ACT_LIT);

    // R8: a strobe lights the indicator on the following cycle
    a_r8_lit_on_strobe: assert property (@(posedge clk) disable iff (rst)
        trigger |=> active);
    // R8: the indicator stays lit until the stretch count is used up
    a_r8_stays_lit: assert property (@(posedge clk) disable iff (rst)
        (active && !(&cnt)) |=> active);
endmodule

// File: rtl/audio_pdm_dac.sv
module audio_pdm_dac
    import pdm_dac_pkg::*;
#(
    parameter int ACT_LOG2 = 20
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rx_valid,
    input  logic [SAMPLE_W-1:0] rx_byte,
    input  logic [VOL_W-1:0]    volume,
    output logic                audio_out,
    output logic                rx_active
);
    localparam int HOLD_LOG2 = SAMPLE_W + 1;

    pcm_t  held;
    code_t level;

    sample_capture u_cap (
        .clk      (clk),
        .rst      (rst),
        .strobe   (rx_valid),
        .byte_in  (rx_byte),
        .sample_q (held)
    );

    vol_scaler u_scl (
        .sample (held),
        .vol    (volume),
        .level  (level)
    );

    pdm_modulator #(.HOLD_LOG2(HOLD_LOG2)) u_mod (
        .clk      (clk),
        .rst      (rst),
        .level_in (level),
        .pin      (audio_out)
    );

    activity_stretch #(.LEN_LOG2(ACT_LOG2)) u_act (
        .clk     (clk),
        .rst     (rst),
        .trigger (rx_valid),
        .active  (rx_active)
    );
endmodule

// File: tb/tb_audio_pdm_dac.sv
module tb_audio_pdm_dac;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 512;
    localparam int ACT_LOG2   = 4;
    localparam int ACT_LEN    = 1 << ACT_LOG2;
    localparam int LAST_PER   = 13;

    typedef struct {
        int    ones;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic [2:0] volume = 3'd4;
    logic       audio_out;
    logic       rx_active;

    int   checks = 0;
    int   fails = 0;
    int   ecnt = 0;
    int   ones = 0;
    bit   done = 1'b0;
    exp_t q[$];

    audio_pdm_dac #(.ACT_LOG2(ACT_LOG2)) dut (
        .clk       (clk),
        .rst       (rst),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .volume    (volume),
        .audio_out (audio_out),
        .rx_active (rx_active)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) if (!rst) ecnt <= ecnt + 1;

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected number of ones in one hold period, from R2, R3 and R5
    function automatic int exp_ones(logic [7:0] b, logic [2:0] v);
        logic signed [7:0] s;
        logic [7:0]        u;
        s = $signed({~b[7], b[6:0]});
        s = s >>> (3'd7 - v);
        u = {~s[7], s[6:0]};
        return 2 * int'(u);
    endfunction

    // Monitor: counts pin ones over each window and compares with the scoreboard
    always @(negedge clk) begin
        if (!rst && ecnt >= 2 && !done) begin
            ones = ones + int'(audio_out);
            if ((ecnt - 2) % HOLD == HOLD - 1) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R5 empty scoreboard", ones, -1);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(ones == e.ones, e.tag, ones, e.ones);
                end
                ones = 0;
            end
        end
    end

    task automatic wait_edge(int target);
        while (ecnt != target) @(negedge clk);
    endtask

    // Driver: strobe a byte inside period m-1 so that it is used in period m
    task automatic send(int m, int offs, logic [7:0] b, logic [2:0] v,
                        string tag, bit act_chk);
        int s;
        wait_edge(HOLD * (m - 1) + offs);
        rx_valid = 1'b1;
        rx_byte  = b;
        volume   = v;
        @(negedge clk);
        rx_valid = 1'b0;
        rx_byte  = ~b;
        s = ecnt;
        if (act_chk) begin
            chk(rx_active == 1'b1, "R8 lit after strobe", int'(rx_active), 1);
            wait_edge(s + ACT_LEN - 1);
            chk(rx_active == 1'b1, "R8 last lit cycle", int'(rx_active), 1);
            wait_edge(s + ACT_LEN);
            chk(rx_active == 1'b0, "R8 dark after stretch", int'(rx_active), 0);
        end
    endtask

    task automatic push(int m_unused, int n, string tag);
        exp_t e;
        e.ones = n;
        e.tag  = tag;
        q.push_back(e);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(audio_out == 1'b0, "R7 pin low in reset", int'(audio_out), 0);
        chk(rx_active == 1'b0, "R7 R8 indicator low in reset", int'(rx_active), 0);
        push(0, 256, "R7 first period half density");
        rst = 1'b0;
        @(negedge clk);

        push(1, exp_ones(8'h80, 3'd4), "R2 mid-scale byte");
        send(1, 100, 8'h80, 3'd4, "R2", 1'b1);
        push(2, exp_ones(8'hFF, 3'd7), "R2 full-scale byte");
        send(2, 100, 8'hFF, 3'd7, "R2", 1'b1);
        push(3, exp_ones(8'h00, 3'd7), "R2 most negative byte");
        send(3, 100, 8'h00, 3'd7, "R2", 1'b1);
        push(4, exp_ones(8'hFF, 3'd4), "R3 vol4 positive");
        send(4, 100, 8'hFF, 3'd4, "R3", 1'b0);
        push(5, exp_ones(8'h00, 3'd4), "R3 vol4 negative");
        send(5, 100, 8'h00, 3'd4, "R3", 1'b0);
        push(6, exp_ones(8'h00, 3'd0), "R3 vol0 negative sign kept");
        send(6, 100, 8'h00, 3'd0, "R3", 1'b0);
        push(7, exp_ones(8'hFF, 3'd0), "R3 vol0 positive");
        send(7, 100, 8'hFF, 3'd0, "R3", 1'b0);
        push(8, exp_ones(8'h40, 3'd5), "R3 vol5");
        send(8, 100, 8'h40, 3'd5, "R3", 1'b0);
        push(9, exp_ones(8'hC0, 3'd6), "R3 vol6");
        send(9, 100, 8'hC0, 3'd6, "R3", 1'b0);
        push(10, exp_ones(8'h81, 3'd7), "R5 one step above zero");
        send(10, 100, 8'h81, 3'd7, "R5", 1'b0);

        // Period 11: bytes change without a strobe; the level must not move
        push(11, exp_ones(8'h81, 3'd7), "R1 bytes without strobe ignored");
        wait_edge(HOLD * 10 + 50);
        for (int i = 0; i < 40; i++) begin
            rx_byte = 8'(i * 37 + 5);
            @(negedge clk);
        end

        // Period 12: two strobes, the later one wins
        push(12, exp_ones(8'hFF, 3'd7), "R6 last strobe wins");
        send(12, 100, 8'h00, 3'd7, "R6", 1'b0);
        send(12, 110, 8'hFF, 3'd7, "R6", 1'b0);
        wait_edge(HOLD * 11 + 111 + ACT_LEN - 1);
        chk(rx_active == 1'b1, "R8 restarted by second strobe", int'(rx_active), 1);

        // Period 13: a strobe just before the boundary takes effect only after it
        push(13, exp_ones(8'h00, 3'd7), "R4 late strobe waits for boundary");
        send(13, 500, 8'h00, 3'd7, "R4", 1'b0);

        wait_edge(HOLD * (LAST_PER + 1) + 4);
        done = 1'b1;
        chk(q.size() == 0, "R5 scoreboard drained", q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", ecnt, HOLD * (LAST_PER + 1));
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule